// File: doc/BRIEF.md
# Lockable Translation Buffer with Round-Robin Victim

This block is the translation buffer of a device-side address translator. A fully associative array of entries maps 32-bit device virtual addresses onto physical addresses. Each entry covers one of four page sizes. A lookup port returns, one cycle after a request, either a hit flag with the translated address or a miss flag. On a miss the faulting address is latched. The block does not walk page tables: a miss is only reported.

Software fills and maintains the array through a command port. A lock pair of two indices steers replacement. The first index, the floor, marks the preserved region at the bottom of the array, which is never replaced. The second, the victim, names the next slot to be written. A plain load writes the victim slot and advances the victim round-robin, wrapping back to the floor. A preserved load writes the slot at the floor and raises the floor by one. Other commands read back the slot named by the victim, invalidate every entry covering an address, set the lock pair directly, and flush the whole array.

Command codes on `cmd_op`: 0 idle, 1 set lock, 2 load, 3 read, 4 invalidate by address, 5 flush all. CAM word layout: bits [31:12] virtual page start, bit 2 valid (readback only, ignored on load), bits [11:3] read back as zero, bits [1:0] page size. RAM word layout: bits [31:12] physical page base, bits [11:0] attributes, which are stored and read back but play no part in translation.

Top module: `xlat_tlb`

## Requirements
- R1: After reset the floor and victim are 0, `lk_hit`, `lk_miss` and `load_busy` are low, and no entry is valid, so any lookup misses.
- R2: A load with `cmd_keep` low writes `cmd_cam`/`cmd_ram` into the slot named by the victim, marks it valid, and advances the victim by one.
- R3: When a plain load advances the victim to the entry count, the victim becomes the floor instead of the entry count.
- R4: A load with `cmd_keep` high writes the slot at the floor, then sets the floor to its old value plus one and the victim to that same new value. The floor never exceeds the entry count.
- R5: A load is refused when the floor equals the entry count, or when it is a plain load and the victim is at or above the entry count. On a refused load `load_busy` is high for the one cycle after the command, no entry changes, and both indices keep their values.
- R6: Size code 0 is a 4 KB page, 1 is 64 KB, 2 is 1 MB and 3 is 16 MB. An entry hits when it is valid and the address lies from its page start, aligned down to the page size, up to but not including start plus size. `lk_pa` is then the RAM page base above the page offset and the request address within it. Both `lk_hit` and `lk_pa` appear one cycle after `lk_req`.
- R7: A lookup that hits no entry raises `lk_miss` for one cycle and latches the request address into `fault_va`. That value holds until the next miss.
- R8: A read command returns, one cycle later on `rd_cam`/`rd_ram`, the CAM word with its valid bit and the RAM word of the slot named by the victim.
- R9: Invalidate-by-address clears the valid bit of every valid entry that covers `cmd_va`, in one command, and leaves the floor, the victim and all other entries unchanged.
- R10: Flush-all clears every valid bit and sets the floor and the victim to 0.
- R11: Set-lock loads `cmd_base` into the floor and `cmd_vict` into the victim.
- R12: When several valid entries cover an address, the lowest-numbered entry supplies the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_keep | input | 1 | Load into the preserved region |
| cmd_cam | input | ADDR_W | CAM word staged for a load |
| cmd_ram | input | ADDR_W | RAM word staged for a load |
| cmd_va | input | ADDR_W | Address for invalidate-by-address |
| cmd_base | input | IW | Floor value for set-lock |
| cmd_vict | input | IW | Victim value for set-lock |
| lock_base | output | IW | Current floor of the replaceable region |
| lock_vict | output | IW | Current victim index |
| load_busy | output | 1 | Refused-load pulse |
| rd_cam | output | ADDR_W | Readback CAM word |
| rd_ram | output | ADDR_W | Readback RAM word |
| lk_req | input | 1 | Lookup request |
| lk_va | input | ADDR_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit, one cycle after request |
| lk_miss | output | 1 | Lookup miss, one cycle after request |
| lk_pa | output | ADDR_W | Translated physical address |
| fault_va | output | ADDR_W | Address of the latest miss |

## Verification
The bench builds the block with four entries and 32-bit addresses. This lets a handful of loads fill the array, wrap the victim back to a non-zero floor and then push the preserved region to the full array. Once the region is full, both refusal cases, plain and preserved, can be reached. The four entries carry one page of each size, so every size code, both page edges and the overlap priority between a large and a small page are covered within a short run.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_SETLOCK = 3'd1,
    OP_LOAD    = 3'd2,
    OP_READ    = 3'd3,
    OP_INVAL   = 3'd4,
    OP_FLUSH   = 3'd5
  } tlb_op_e;

  localparam int PAGE_LSB = 12;

  // offset width for size codes 0..3: 12, 16, 20, 24 bits
  function automatic int page_shift(input logic [1:0] sz);
    return PAGE_LSB + 4 * int'(sz);
  endfunction

endpackage

// File: rtl/xlat_tlb_lockctl.sv
module xlat_tlb_lockctl
  import xlat_tlb_pkg::*;
#(
  parameter int NENT = 32,
  parameter int IW   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  tlb_op_e       cmd_op,
  input  logic          cmd_keep,
  input  logic [IW-1:0] set_base,
  input  logic [IW-1:0] set_vict,
  output logic [IW-1:0] base_q,
  output logic [IW-1:0] vict_q,
  output logic          wr_en,
  output logic [IW-1:0] wr_slot,
  output logic          busy_q
);

  localparam logic [IW-1:0] CAP = IW'(NENT);

  logic          is_load;
  logic          refuse;
  logic [IW-1:0] step;

  always_comb begin
    is_load = cmd_valid && (cmd_op == OP_LOAD);
    refuse  = (base_q >= CAP) || (!cmd_keep && (vict_q >= CAP));
    wr_en   = is_load && !refuse;
    wr_slot = cmd_keep ? base_q : vict_q;
    step    = wr_slot + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      vict_q <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= is_load && refuse;
      if (cmd_valid) begin
        case (cmd_op)
          OP_SETLOCK: begin
            base_q <= set_base;
            vict_q <= set_vict;
          end
          OP_FLUSH: begin
            base_q <= '0;
            vict_q <= '0;
          end
          OP_LOAD: begin
            if (!refuse) begin
              if (cmd_keep) begin
                base_q <= step;
                vict_q <= step;
              end else begin
                vict_q <= (step == CAP) ? base_q : step;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/xlat_tlb_array.sv
module xlat_tlb_array
  import xlat_tlb_pkg::*;
#(
  parameter int NENT   = 32,
  parameter int IW     = 6,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_slot,
  input  logic [ADDR_W-1:PAGE_LSB] wr_vpn,
  input  logic [1:0]               wr_sz,
  input  logic [ADDR_W-1:0]        wr_ram,
  input  logic                     inval_en,
  input  logic [ADDR_W-1:0]        inval_va,
  input  logic                     clr_all,
  input  logic                     rd_en,
  input  logic [IW-1:0]            rd_slot,
  output logic [ADDR_W-1:0]        rd_cam_q,
  output logic [ADDR_W-1:0]        rd_ram_q,
  input  logic [ADDR_W-1:0]        lk_va,
  output logic [NENT-1:0]          lk_match,
  output logic [NENT*ADDR_W-1:0]   ram_flat,
  output logic [NENT*2-1:0]        sz_flat
);

  localparam int GAP_W = PAGE_LSB - 3;

  logic [NENT*ADDR_W-1:0] cam_flat;

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    logic                     vld;
    logic [ADDR_W-1:PAGE_LSB] vpn;
    logic [1:0]               sz;
    logic [ADDR_W-1:0]        ram;
    logic [ADDR_W-1:0]        msk;
    logic [ADDR_W-1:0]        start;
    logic                     hit_inv;
    logic                     sel;

    assign sel     = wr_en && (wr_slot == IW'(g));
    assign msk     = {ADDR_W{1'b1}} >> (ADDR_W - page_shift(sz));
    assign start   = {vpn, {PAGE_LSB{1'b0}}};
    assign lk_match[g] = vld && ((lk_va & ~msk) == (start & ~msk));
    assign hit_inv = vld && ((inval_va & ~msk) == (start & ~msk));

    assign ram_flat[g*ADDR_W +: ADDR_W] = ram;
    assign sz_flat[g*2 +: 2]            = sz;
    assign cam_flat[g*ADDR_W +: ADDR_W] = {vpn, {GAP_W{1'b0}}, vld, sz};

    always_ff @(posedge clk) begin
      if (rst) begin
        vld <= 1'b0;
        vpn <= '0;
        sz  <= '0;
        ram <= '0;
      end else begin
        if (clr_all) vld <= 1'b0;
        else if (sel) vld <= 1'b1;
        else if (inval_en && hit_inv) vld <= 1'b0;
        if (sel) begin
          vpn <= wr_vpn;
          sz  <= wr_sz;
          ram <= wr_ram;
        end
      end
    end
  end

  logic [ADDR_W-1:0] pick_cam, pick_ram;

  always_comb begin
    pick_cam = '0;
    pick_ram = '0;
    for (int i = 0; i < NENT; i++) begin
      if (rd_slot == IW'(i)) begin
        pick_cam = cam_flat[i*ADDR_W +: ADDR_W];
        pick_ram = ram_flat[i*ADDR_W +: ADDR_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cam_q <= '0;
      rd_ram_q <= '0;
    end else if (rd_en) begin
      rd_cam_q <= pick_cam;
      rd_ram_q <= pick_ram;
    end
  end

endmodule

// File: rtl/xlat_tlb_lookup.sv
module xlat_tlb_lookup
  import xlat_tlb_pkg::*;
#(
  parameter int NENT   = 32,
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lk_req,
  input  logic [ADDR_W-1:0]      lk_va,
  input  logic [NENT-1:0]        lk_match,
  input  logic [NENT*ADDR_W-1:0] ram_flat,
  input  logic [NENT*2-1:0]      sz_flat,
  output logic                   hit_q,
  output logic                   miss_q,
  output logic [ADDR_W-1:0]      pa_q,
  output logic [ADDR_W-1:0]      fault_q
);

  logic              any;
  logic [ADDR_W-1:0] pick_ram;
  logic [1:0]        pick_sz;
  logic [ADDR_W-1:0] msk;
  logic [ADDR_W-1:0] pa_n;

  always_comb begin
    any      = |lk_match;
    pick_ram = '0;
    pick_sz  = '0;
    // descending scan: the lowest matching index is assigned last and wins
    for (int i = NENT - 1; i >= 0; i--) begin
      if (lk_match[i]) begin
        pick_ram = ram_flat[i*ADDR_W +: ADDR_W];
        pick_sz  = sz_flat[i*2 +: 2];
      end
    end
    msk  = {ADDR_W{1'b1}} >> (ADDR_W - page_shift(pick_sz));
    pa_n = (pick_ram & ~msk) | (lk_va & msk);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      miss_q  <= 1'b0;
      pa_q    <= '0;
      fault_q <= '0;
    end else begin
      hit_q  <= lk_req && any;
      miss_q <= lk_req && !any;
      if (lk_req && any)  pa_q    <= pa_n;
      if (lk_req && !any) fault_q <= lk_va;
    end
  end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter  int NENT   = 32,
  parameter  int ADDR_W = 32,
  localparam int IW     = $clog2(NENT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_keep,
  input  logic [ADDR_W-1:0] cmd_cam,
  input  logic [ADDR_W-1:0] cmd_ram,
  input  logic [ADDR_W-1:0] cmd_va,
  input  logic [IW-1:0]     cmd_base,
  input  logic [IW-1:0]     cmd_vict,
  output logic [IW-1:0]     lock_base,
  output logic [IW-1:0]     lock_vict,
  output logic              load_busy,
  output logic [ADDR_W-1:0] rd_cam,
  output logic [ADDR_W-1:0] rd_ram,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_va,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [ADDR_W-1:0] lk_pa,
  output logic [ADDR_W-1:0] fault_va
);

  tlb_op_e               op;
  logic                  wr_en;
  logic [IW-1:0]         wr_slot;
  logic [NENT-1:0]       match;
  logic [NENT*ADDR_W-1:0] ram_flat;
  logic [NENT*2-1:0]     sz_flat;
  logic                  unused_cam_bits;

  assign op              = tlb_op_e'(cmd_op);
  assign unused_cam_bits = ^cmd_cam[PAGE_LSB-1:2];

  xlat_tlb_lockctl #(.NENT(NENT), .IW(IW)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_op   (op),
    .cmd_keep (cmd_keep),
    .set_base (cmd_base),
    .set_vict (cmd_vict),
    .base_q   (lock_base),
    .vict_q   (lock_vict),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .busy_q   (load_busy)
  );

  xlat_tlb_array #(.NENT(NENT), .IW(IW), .ADDR_W(ADDR_W)) u_arr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_vpn  (cmd_cam[ADDR_W-1:PAGE_LSB]),
    .wr_sz   (cmd_cam[1:0]),
    .wr_ram  (cmd_ram),
    .inval_en(cmd_valid && (op == OP_INVAL)),
    .inval_va(cmd_va),
    .clr_all (cmd_valid && (op == OP_FLUSH)),
    .rd_en   (cmd_valid && (op == OP_READ)),
    .rd_slot (lock_vict),
    .rd_cam_q(rd_cam),
    .rd_ram_q(rd_ram),
    .lk_va   (lk_va),
    .lk_match(match),
    .ram_flat(ram_flat),
    .sz_flat (sz_flat)
  );

  xlat_tlb_lookup #(.NENT(NENT), .ADDR_W(ADDR_W)) u_lk (
    .clk     (clk),
    .rst     (rst),
    .lk_req  (lk_req),
    .lk_va   (lk_va),
    .lk_match(match),
    .ram_flat(ram_flat),
    .sz_flat (sz_flat),
    .hit_q   (lk_hit),
    .miss_q  (lk_miss),
    .pa_q    (lk_pa),
    .fault_q (fault_va)
  );

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int NENT   = 32,
  parameter int ADDR_W = 32,
  parameter int IW     = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              cmd_keep,
  input logic [IW-1:0]     cmd_base,
  input logic [IW-1:0]     cmd_vict,
  input logic [IW-1:0]     lock_base,
  input logic [IW-1:0]     lock_vict,
  input logic              load_busy,
  input logic              lk_req,
  input logic [ADDR_W-1:0] lk_va,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic [ADDR_W-1:0] fault_va
);

  localparam logic [IW-1:0] CAP = IW'(NENT);

  p_base_cap_r4: assert property (@(posedge clk) disable iff (rst)
    lock_base <= CAP);

  p_keep_grow_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd2 && cmd_keep && lock_base < CAP)
    |=> (lock_base == $past(lock_base) + IW'(1)) && (lock_vict == lock_base));

  p_wrap_floor_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd2 && !cmd_keep && lock_base < CAP
     && lock_vict == CAP - IW'(1))
    |=> lock_vict == $past(lock_base));

  p_refuse_full_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd2 && lock_base == CAP)
    |=> load_busy && $stable(lock_base) && $stable(lock_vict));

  p_one_result_r6: assert property (@(posedge clk) disable iff (rst)
    !(lk_hit && lk_miss));

  p_result_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_hit && !lk_miss);

  p_fault_latch_r7: assert property (@(posedge clk) disable iff (rst)
    (lk_req) |=> (lk_miss -> fault_va == $past(lk_va)));

  p_flush_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd5) |=> lock_base == '0 && lock_vict == '0);

  p_set_lock_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd1)
    |=> lock_base == $past(cmd_base) && lock_vict == $past(cmd_vict));

endmodule

bind xlat_tlb xlat_tlb_chk #(.NENT(NENT), .ADDR_W(ADDR_W), .IW(IW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .cmd_op   (cmd_op),
  .cmd_keep (cmd_keep),
  .cmd_base (cmd_base),
  .cmd_vict (cmd_vict),
  .lock_base(lock_base),
  .lock_vict(lock_vict),
  .load_busy(load_busy),
  .lk_req   (lk_req),
  .lk_va    (lk_va),
  .lk_hit   (lk_hit),
  .lk_miss  (lk_miss),
  .fault_va (fault_va)
);

// File: tb/test_xlat_tlb.sv
`timescale 1ns/1ps
module test_xlat_tlb;

  localparam int NENT = 4;
  localparam int AW   = 32;
  localparam int IW   = $clog2(NENT + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic          cmd_keep = 1'b0;
  logic [AW-1:0] cmd_cam = '0, cmd_ram = '0, cmd_va = '0;
  logic [IW-1:0] cmd_base = '0, cmd_vict = '0;
  logic [IW-1:0] lock_base, lock_vict;
  logic          load_busy;
  logic [AW-1:0] rd_cam, rd_ram;
  logic          lk_req = 1'b0;
  logic [AW-1:0] lk_va = '0;
  logic          lk_hit, lk_miss;
  logic [AW-1:0] lk_pa, fault_va;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  xlat_tlb #(.NENT(NENT), .ADDR_W(AW)) i_xlat_tlb (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_keep(cmd_keep), .cmd_cam(cmd_cam), .cmd_ram(cmd_ram), .cmd_va(cmd_va),
    .cmd_base(cmd_base), .cmd_vict(cmd_vict), .lock_base(lock_base),
    .lock_vict(lock_vict), .load_busy(load_busy), .rd_cam(rd_cam), .rd_ram(rd_ram),
    .lk_req(lk_req), .lk_va(lk_va), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_pa(lk_pa), .fault_va(fault_va)
  );

  // {expect hit, lookup address, expected physical address}
  localparam logic [64:0] VEC [11] = '{
    {1'b1, 32'h10AB_CDEF, 32'h80AB_CDEF},
    {1'b1, 32'h10FF_FFFF, 32'h80FF_FFFF},
    {1'b0, 32'h1100_0000, 32'h0},
    {1'b1, 32'h200F_FFFF, 32'h401F_FFFF},
    {1'b0, 32'h2010_0000, 32'h0},
    {1'b1, 32'h3001_2345, 32'h0567_2345},
    {1'b0, 32'h3002_0000, 32'h0},
    {1'b0, 32'h3000_FFFF, 32'h0},
    {1'b1, 32'h4000_3ABC, 32'h0ABC_DABC},
    {1'b0, 32'h4000_4000, 32'h0},
    {1'b1, 32'h1000_0000, 32'h8000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic keep, input logic [31:0] cam,
                     input logic [31:0] ram, input logic [31:0] va,
                     input logic [IW-1:0] b, input logic [IW-1:0] v);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_keep = keep; cmd_cam = cam;
    cmd_ram = ram; cmd_va = va; cmd_base = b; cmd_vict = v;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_keep = 1'b0;
  endtask

  task automatic load(input logic keep, input logic [31:0] cam, input logic [31:0] ram);
    cmd(3'd2, keep, cam, ram, 32'h0, '0, '0);
  endtask

  task automatic setlock(input logic [IW-1:0] b, input logic [IW-1:0] v);
    cmd(3'd1, 1'b0, 32'h0, 32'h0, 32'h0, b, v);
  endtask

  task automatic look(input logic [31:0] va);
    @(negedge clk);
    lk_req = 1'b1; lk_va = va;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 base", 32'(lock_base), 0);
    chk("R1 vict", 32'(lock_vict), 0);
    chk("R1 hit", 32'(lk_hit), 0);
    chk("R1 miss", 32'(lk_miss), 0);
    chk("R1 busy", 32'(load_busy), 0);
    look(32'h0);
    chk("R1 empty miss", 32'(lk_miss), 1);

    // R4 preserved load to slot 0
    load(1'b1, 32'h1000_0003, 32'h8000_0005);
    chk("R4 base", 32'(lock_base), 1);
    chk("R4 vict", 32'(lock_vict), 1);
    chk("R4 no busy", 32'(load_busy), 0);
    // R2 plain loads
    load(1'b0, 32'h2000_0002, 32'h4010_0000);
    chk("R2 vict", 32'(lock_vict), 2);
    load(1'b0, 32'h3001_0001, 32'h0567_0000);
    chk("R2 vict", 32'(lock_vict), 3);
    load(1'b0, 32'h4000_3000, 32'h0ABC_D000);
    // R3 wrap to floor
    chk("R3 wrap", 32'(lock_vict), 1);
    chk("R3 base", 32'(lock_base), 1);

    // R6/R7 lookup vectors
    for (int i = 0; i < 11; i++) begin
      look(VEC[i][63:32]);
      chk("R6 hit", 32'(lk_hit), 32'(VEC[i][64]));
      if (VEC[i][64]) chk("R6 pa", lk_pa, VEC[i][31:0]);
      else begin
        chk("R7 miss", 32'(lk_miss), 1);
        chk("R7 fault", fault_va, VEC[i][63:32]);
      end
    end

    // R11 and R8 readback of slot 2
    setlock(3'd1, 3'd2);
    chk("R11 base", 32'(lock_base), 1);
    chk("R11 vict", 32'(lock_vict), 2);
    cmd(3'd3, 1'b0, 0, 0, 0, '0, '0);
    chk("R8 cam", rd_cam, 32'h3001_0005);
    chk("R8 ram", rd_ram, 32'h0567_0000);
    setlock(3'd1, 3'd1);

    // R12 overlapping small page in slot 1
    load(1'b0, 32'h1000_0000, 32'h0222_2000);
    chk("R2 vict", 32'(lock_vict), 2);
    look(32'h1000_0123);
    chk("R12 hit", 32'(lk_hit), 1);
    chk("R12 pa", lk_pa, 32'h8000_0123);

    // R9 invalidate by address
    cmd(3'd4, 1'b0, 0, 0, 32'h1000_0123, '0, '0);
    chk("R9 base", 32'(lock_base), 1);
    chk("R9 vict", 32'(lock_vict), 2);
    look(32'h1000_0123);
    chk("R9 miss", 32'(lk_miss), 1);
    chk("R7 fault", fault_va, 32'h1000_0123);
    look(32'h10AB_CDEF);
    chk("R9 big gone", 32'(lk_miss), 1);
    look(32'h3001_2345);
    chk("R9 other kept", 32'(lk_hit), 1);
    chk("R7 fault hold", fault_va, 32'h10AB_CDEF);
    setlock(3'd1, 3'd0);
    cmd(3'd3, 1'b0, 0, 0, 0, '0, '0);
    chk("R9 valid clear", rd_cam, 32'h1000_0003);
    chk("R8 ram", rd_ram, 32'h8000_0005);
    setlock(3'd1, 3'd2);

    // R4 fill preserved region
    load(1'b1, 32'h5000_0000, 32'h0600_0000);
    chk("R4 base", 32'(lock_base), 2);
    load(1'b1, 32'h6000_0000, 32'h0700_0000);
    load(1'b1, 32'h7000_0000, 32'h0800_0000);
    chk("R4 base full", 32'(lock_base), 4);
    chk("R4 vict full", 32'(lock_vict), 4);
    look(32'h7000_0456);
    chk("R4 entry", lk_pa, 32'h0800_0456);

    // R5 refusals
    load(1'b1, 32'h9000_0000, 32'h0900_0000);
    chk("R5 busy keep", 32'(load_busy), 1);
    chk("R5 base", 32'(lock_base), 4);
    chk("R5 vict", 32'(lock_vict), 4);
    load(1'b0, 32'h9000_0000, 32'h0900_0000);
    chk("R5 busy plain", 32'(load_busy), 1);
    look(32'h9000_0000);
    chk("R5 nothing written", 32'(lk_miss), 1);
    look(32'h5000_0010);
    chk("R5 entries kept", lk_pa, 32'h0600_0010);

    // R10 flush all
    cmd(3'd5, 1'b0, 0, 0, 0, '0, '0);
    chk("R10 base", 32'(lock_base), 0);
    chk("R10 vict", 32'(lock_vict), 0);
    look(32'h5000_0010);
    chk("R10 miss", 32'(lk_miss), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule